// File: doc/BRIEF.md
# Three-Channel Shared-Period PWM

This block drives three pulse-width-modulated outputs from a single up-counter. All three outputs share one programmable 14-bit period. Each output has its own 14-bit duty threshold and stays high while the shared count is below that threshold. The counter moves only in clock cycles where the `tick` clock-enable is high, so a prescaler outside the block sets the output frequency.

Software programs the block through a simple register port. Writes are taken on the clock edge and reads are combinational. The port holds a control word (enable, software pause, hardware-pause allow), the period and the three duty values. A pause request can come from software or, if software allows it, from the `hw_pause_req` pin. A pause forces all outputs low and freezes the counter, and counting resumes from the frozen value. New period and duty values are staged and applied only at the counter wrap, so no pulse is ever cut short or stretched by a write.

A three-state controller sequences the block:
- The states are OFF, RUN and HOLD.
- OFF goes to RUN when the enable bit is set with no pause active (START).
- OFF goes to HOLD when the enable bit is set while a pause is active (START_PAUSED).
- RUN goes to HOLD on a pause (FREEZE), and HOLD goes back to RUN when the pause is released (THAW).
- RUN or HOLD goes to OFF when the enable bit is cleared (STOP).

Top module: `tri_pwm`

## Requirements
- R1: After reset, every register reads 0 and `pwm_out` is 0.
- R2: Register map and write/read behaviour:
  - A write happens on the clock edge where `reg_wr` is 1, and `reg_rdata` shows the register selected by `reg_addr` in the same cycle.
  - Address 0 is the control word: bit 0 enables the block, bit 1 is the software pause, bit 2 allows the hardware pause. Its other bits read 0.
  - Address 1 is the period, held in bits 13:0.
  - Addresses 2, 3 and 4 are the duty values of channels 0, 1 and 2, held in bits 13:0.
  - Addresses 5 to 7 ignore writes and read 0.
- R3: Clearing the enable bit drives `pwm_out` low from the second clock edge after the write edge and clears the count. After the enable bit is set, the first output cycle (after the second edge) reflects count 0.
- R4: With `tick` high in every cycle, the shared count steps 0, 1, … up to the period value and then back to 0. `pwm_out[i]` is high exactly while the count is less than the duty of channel i.
- R5: A duty of 0 keeps that output always low. A duty greater than the period keeps that output always high.
- R6: Setting the software pause bit drives all outputs low from the second edge after the write edge and freezes the count. After the bit is cleared, the outputs continue from the frozen count.
- R7: When the hardware-pause allow bit is 1, `hw_pause_req` high drives all outputs low from the next edge and freezes the count, and counting resumes from the frozen count after release. When the allow bit is 0, `hw_pause_req` has no effect.
- R8: Period and duty values written while running take effect at the next wrap from the period value to 0. Values written while disabled take effect when the block is enabled.
- R9: In a cycle where `tick` is 0 the count does not move. With `tick` high every other cycle, each count value lasts two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Counter clock-enable |
| hw_pause_req | input | 1 | External pause request |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| pwm_out | output | 3 | PWM outputs, bit i is channel i |

## Verification
The bench rewrites a duty value and then the period partway through a period. It checks that the rest of that period keeps the old shape and that the new values appear exactly at the wrap; a design that applied writes at once would show a cut or stretched pulse.

Both pause paths are released after several held cycles, and the outputs must continue from the frozen count. A design that let the counter run during a pause, or reset it on release, would shift the pattern.

The bench also covers:
- Duty values of 0, exactly period+1 and above period+1. An off-by-one compare would show one stray low or high cycle per period.
- A tick on every other cycle, which exposes a counter that ignores the clock-enable.
- `hw_pause_req` asserted while the allow bit is clear, which exposes a design that pauses anyway.

// File: rtl/tri_pwm_pkg.sv
package tri_pwm_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } pwm_state_e;

    localparam int ADDR_CTRL   = 0;
    localparam int ADDR_PERIOD = 1;
    localparam int ADDR_DUTY0  = 2;

    localparam int CTRL_BITS   = 3;
    localparam int CTRL_EN     = 0;
    localparam int CTRL_SWP    = 1;
    localparam int CTRL_HWA    = 2;

endpackage

// File: rtl/tri_pwm_regs.sv
module tri_pwm_regs
    import tri_pwm_pkg::*;
#(
    parameter int CH = 3,
    parameter int CW = 14,
    parameter int DW = 16,
    parameter int AW = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          addr,
    input  logic [DW-1:0]          wdata,
    output logic [DW-1:0]          rdata,
    output logic                   en,
    output logic                   sw_pause,
    output logic                   hw_allow,
    output logic [CW-1:0]          period,
    output logic [CH-1:0][CW-1:0]  duty
);

    logic [CTRL_BITS-1:0] ctrl_q;
    logic [CW-1:0]        period_q;
    logic [CH-1:0][CW-1:0] duty_q;
    logic                 wdata_unused_bits;

    assign wdata_unused_bits = ^wdata[DW-1:CW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            period_q <= '0;
            duty_q   <= '0;
        end else if (wr_en) begin
            if (addr == AW'(ADDR_CTRL))
                ctrl_q <= wdata[CTRL_BITS-1:0];
            if (addr == AW'(ADDR_PERIOD))
                period_q <= wdata[CW-1:0];
            for (int i = 0; i < CH; i++) begin
                if (addr == AW'(ADDR_DUTY0 + i))
                    duty_q[i] <= wdata[CW-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == AW'(ADDR_CTRL))
            rdata = {{(DW-CTRL_BITS){1'b0}}, ctrl_q};
        if (addr == AW'(ADDR_PERIOD))
            rdata = {{(DW-CW){1'b0}}, period_q};
        for (int i = 0; i < CH; i++) begin
            if (addr == AW'(ADDR_DUTY0 + i))
                rdata = {{(DW-CW){1'b0}}, duty_q[i]};
        end
    end

    assign en       = ctrl_q[CTRL_EN];
    assign sw_pause = ctrl_q[CTRL_SWP];
    assign hw_allow = ctrl_q[CTRL_HWA];
    assign period   = period_q;
    assign duty     = duty_q;

endmodule

// File: rtl/tri_pwm_seq.sv
module tri_pwm_seq
    import tri_pwm_pkg::*;
#(
    parameter int CW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          en,
    input  logic          pause,
    input  logic [CW-1:0] period_in,
    output pwm_state_e    state_o,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] period_act_o,
    output logic          load_o,
    output logic          run_o
);

    pwm_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] period_q;
    logic          advance;
    logic          wrap;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (en) state_d = pause ? ST_HOLD : ST_RUN;
            ST_RUN:  if (!en) state_d = ST_OFF;
                     else if (pause) state_d = ST_HOLD;
            ST_HOLD: if (!en) state_d = ST_OFF;
                     else if (!pause) state_d = ST_RUN;
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // output decode
    always_comb begin
        advance = (state_q == ST_RUN) && (state_d == ST_RUN) && tick;
        wrap    = advance && (cnt_q == period_q);
        load_o  = (state_q == ST_OFF) || wrap;
        run_o   = (state_q == ST_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            period_q <= '0;
        end else begin
            if (state_q == ST_OFF)
                cnt_q <= '0;
            else if (advance)
                cnt_q <= wrap ? '0 : cnt_q + 1'b1;
            if (load_o)
                period_q <= period_in;
        end
    end

    assign state_o      = state_q;
    assign cnt_o        = cnt_q;
    assign period_act_o = period_q;

endmodule

// File: rtl/tri_pwm_chan.sv
module tri_pwm_chan #(
    parameter int CW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] duty_in,
    input  logic [CW-1:0] cnt,
    input  logic          run,
    output logic          pwm,
    output logic [CW-1:0] duty_act
);

    logic [CW-1:0] duty_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    duty_q <= '0;
        else if (load) duty_q <= duty_in;
    end

    assign pwm      = run && (cnt < duty_q);
    assign duty_act = duty_q;

endmodule

// File: rtl/tri_pwm.sv
module tri_pwm
    import tri_pwm_pkg::*;
#(
    parameter int CH = 3,
    parameter int CW = 14,
    parameter int DW = 16,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          hw_pause_req,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic [CH-1:0] pwm_out
);

    logic                  en, sw_pause, hw_allow, pause;
    logic [CW-1:0]         period;
    logic [CH-1:0][CW-1:0] duty;
    logic [CH-1:0][CW-1:0] duty_act;
    pwm_state_e            state;
    logic [CW-1:0]         cnt;
    logic [CW-1:0]         period_act;
    logic                  load, run;

    tri_pwm_regs #(.CH(CH), .CW(CW), .DW(DW), .AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .en       (en),
        .sw_pause (sw_pause),
        .hw_allow (hw_allow),
        .period   (period),
        .duty     (duty)
    );

    assign pause = sw_pause || (hw_allow && hw_pause_req);

    tri_pwm_seq #(.CW(CW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .en           (en),
        .pause        (pause),
        .period_in    (period),
        .state_o      (state),
        .cnt_o        (cnt),
        .period_act_o (period_act),
        .load_o       (load),
        .run_o        (run)
    );

    for (genvar g = 0; g < CH; g++) begin : g_chan
        tri_pwm_chan #(.CW(CW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load),
            .duty_in  (duty[g]),
            .cnt      (cnt),
            .run      (run),
            .pwm      (pwm_out[g]),
            .duty_act (duty_act[g])
        );
    end

endmodule

// File: rtl/tri_pwm_chk.sv
module tri_pwm_chk
    import tri_pwm_pkg::*;
#(
    parameter int CH = 3,
    parameter int CW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          hw_allow,
    input  logic          hw_pause_req,
    input  logic          pause,
    input  pwm_state_e    state,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] period_act,
    input  logic [CW-1:0] duty0_act,
    input  logic [CH-1:0] pwm_out
);

    // R3
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> (pwm_out == '0));

    // R7
    hw_pause_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hw_allow && hw_pause_req) |-> (pwm_out == '0));

    // R6
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pause && state != ST_OFF) |=> $stable(cnt));

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= period_act);

    // R8
    period_wrap_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> $stable(period_act));

    // R5
    full_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && duty0_act > period_act) |-> pwm_out[0]);

endmodule

bind tri_pwm tri_pwm_chk #(.CH(CH), .CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .hw_allow     (hw_allow),
    .hw_pause_req (hw_pause_req),
    .pause        (pause),
    .state        (state),
    .cnt          (cnt),
    .period_act   (period_act),
    .duty0_act    (duty_act[0]),
    .pwm_out      (pwm_out)
);

// File: tb/test_tri_pwm.sv
module test_tri_pwm;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        hw_pause_req = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [2:0]  pwm_out;

    int checks = 0;
    int fails  = 0;
    int p, d0, d1, d2;

    always #2 clk = ~clk;

    tri_pwm i_tri_pwm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .hw_pause_req (hw_pause_req),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .pwm_out      (pwm_out)
    );

    function automatic logic [2:0] expv(int c);
        return {c < d2, c < d1, c < d0};
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 16'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(string tag, int a, int exp);
        @(negedge clk);
        reg_addr = 3'(a);
        #1;
        chk(tag, reg_rdata, 16'(exp));
    endtask

    task automatic smp(string tag, int c);
        @(negedge clk);
        chk(tag, {13'd0, pwm_out}, {13'd0, expv(c)});
    endtask

    task automatic smp_low(string tag);
        @(negedge clk);
        chk(tag, {13'd0, pwm_out}, 16'd0);
    endtask

    task automatic setup(int np, int n0, int n1, int n2, int ctrl);
        wr(0, 0);
        wr(1, np); wr(2, n0); wr(3, n1); wr(4, n2);
        p = np; d0 = n0; d1 = n1; d2 = n2;
        wr(0, ctrl);
    endtask

    task automatic t_reset;
        chk("R1 pwm after reset", {13'd0, pwm_out}, 16'd0);
        for (int a = 0; a < 5; a++) rd("R1 register after reset", a, 0);
    endtask

    task automatic t_regs;
        wr(0, 16'hFFF6); wr(1, 16'hFFFF); wr(2, 16'h1234);
        wr(3, 16'hC005); wr(4, 16'h0ABC); wr(5, 16'h7777);
        rd("R2 ctrl readback", 0, 16'h0006);
        rd("R2 period readback", 1, 16'h3FFF);
        rd("R2 duty0 readback", 2, 16'h1234);
        rd("R2 duty1 readback", 3, 16'h0005);
        rd("R2 duty2 readback", 4, 16'h0ABC);
        rd("R2 unmapped reads 0", 5, 0);
        rd("R2 unmapped reads 0", 7, 0);
        chk("R2 pwm stays low while disabled", {13'd0, pwm_out}, 16'd0);
        wr(0, 0);
    endtask

    task automatic t_basic;
        setup(9, 3, 7, 1, 1);
        for (int i = 0; i < 30; i++) smp("R4 basic pattern", i % 10);
    endtask

    task automatic t_bounds;
        setup(5, 0, 6, 9, 1);
        for (int i = 0; i < 12; i++) smp("R5 duty bounds", i % 6);
    endtask

    task automatic t_shadow;
        setup(9, 3, 2, 12, 1);
        for (int i = 0; i < 20; i++) begin
            if (i == 10) begin p = 4; d0 = 7; end
            smp("R8 update at wrap", (i < 10) ? i : (i - 10) % 5);
            if (i == 4) begin reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 16'd7; end
            if (i == 5) reg_wr = 1'b0;
            if (i == 6) begin reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 16'd4; end
            if (i == 7) reg_wr = 1'b0;
        end
    endtask

    task automatic t_disable;
        setup(9, 4, 0, 10, 1);
        for (int i = 0; i < 4; i++) smp("R3 run before stop", i);
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 16'd0;
        smp("R3 last cycle before stop", 4);
        reg_wr = 1'b0;
        for (int i = 0; i < 4; i++) smp_low("R3 low while disabled");
        wr(2, 2); d0 = 2;
        wr(0, 1);
        for (int i = 0; i < 10; i++) smp("R3 R8 restart from zero", i);
    endtask

    task automatic t_swpause;
        setup(9, 5, 3, 10, 1);
        for (int i = 0; i < 4; i++) smp("R6 before pause", i);
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 16'd3;
        smp("R6 pause write cycle", 4);
        reg_wr = 1'b0;
        for (int i = 0; i < 5; i++) smp_low("R6 low while paused");
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 16'd1;
        smp_low("R6 release write cycle");
        reg_wr = 1'b0;
        for (int k = 0; k < 10; k++) smp("R6 resume from held count", (4 + k) % 10);
    endtask

    task automatic t_hwpause;
        setup(9, 6, 1, 10, 5);
        for (int i = 0; i < 3; i++) smp("R7 before hw pause", i);
        hw_pause_req = 1'b1;
        for (int i = 0; i < 4; i++) smp_low("R7 low while hw paused");
        hw_pause_req = 1'b0;
        for (int k = 0; k < 10; k++) smp("R7 resume from held count", (2 + k) % 10);
    endtask

    task automatic t_hwignored;
        hw_pause_req = 1'b1;
        setup(9, 6, 1, 10, 1);
        for (int i = 0; i < 10; i++) smp("R7 hw request ignored", i);
        hw_pause_req = 1'b0;
    endtask

    task automatic t_tick;
        setup(3, 2, 4, 1, 1);
        tick = 1'b0;
        for (int i = 0; i < 16; i++) begin
            smp("R9 tick gating", (i / 2) % 4);
            tick = (i % 2 == 1);
        end
        tick = 1'b1;
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_basic();
        t_bounds();
        t_shadow();
        t_disable();
        t_swpause();
        t_hwpause();
        t_hwignored();
        t_tick();
        wr(0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule